// File: doc/BRIEF.md
# Predicated Merging SIMD Lane Adder

The block adds two vector operands lane by lane. A 2-bit size code picks the lane width at run time, so the same datapath handles byte, halfword, word and doubleword lanes. A predicate with one bit per byte of the vector decides, lane by lane, whether the lane receives the wrap-around sum or keeps the first operand's value. Because inactive lanes keep the first operand, the result can be written straight back to the register that held that operand. The block produces no condition flags.

Operands enter over a valid/ready input and leave over a valid/ready output through one register stage. An operand set is accepted on a clock edge where `in_valid` and `in_ready` are both high. The sum appears on the next edge with `out_valid` high. It stays there, unchanged, until the consumer raises `out_ready`. While the output is held and `out_ready` is low, `in_ready` is low, so back-pressure reaches the producer in the same cycle. The vector width `VL` is a parameter and must be a multiple of 64.

Top module: `simd_merge_add`

## Requirements
- R1: The size code selects the lane width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. An active lane i holds (a_lane + b_lane) mod 2^width, where a lane covers bits [i*width +: width] and there are VL/width lanes.
- R2: No carry crosses a lane boundary at any lane width. An all-ones lane plus 1 becomes 0 and leaves the lane above unchanged.
- R3: An inactive lane holds the first operand's lane unchanged. With an all-zero predicate the result equals `in_a`.
- R4: A lane of width w is active exactly when predicate bit i*(w/8) is 1, which is the bit of the lane's lowest byte. The other predicate bits under that lane have no effect.
- R5: A transfer is accepted on a rising edge where `in_valid` and `in_ready` are both high. On the next edge `out_valid` is high and `out_result` holds that transfer's result.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid` and `out_result` stay unchanged. `in_ready` is high whenever `out_valid` is low or `out_ready` is high.
- R7: A synchronous active-high `rst` clears `out_valid`. After reset `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Block can take an operand set |
| in_a | input | VL | First operand, merged into inactive lanes |
| in_b | input | VL | Second operand |
| in_pred | input | VL/8 | Predicate, one bit per byte |
| in_size | input | 2 | Lane width code (0:8, 1:16, 2:32, 3:64) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | VL | Lane-wise merged sum |

## Verification
Each result is due exactly one edge after its operands are accepted. The bench's reference model therefore registers its own expected result and valid flag on the same edge the design does. On every falling edge the bench compares `out_valid` and `in_ready` with the model, and compares `out_result` whenever a result is valid. It also holds `out_ready` low for several cycles, so the model must show the held result staying unchanged and `in_ready` staying low for the whole stall.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;
  typedef enum logic [1:0] {
    LW_8  = 2'd0,
    LW_16 = 2'd1,
    LW_32 = 2'd2,
    LW_64 = 2'd3
  } lane_width_e;

  localparam int unsigned NUM_WIDTHS = 4;
endpackage

// File: rtl/simd_lane_ctrl.sv
// Per-byte control: whether the byte starts a lane and whether its lane is active.
module simd_lane_ctrl
  import simd_add_pkg::*;
#(
  parameter int unsigned NB = 32
) (
  input  logic [NB-1:0] pred,
  input  lane_width_e   width,
  output logic [NB-1:0] byte_active,
  output logic [NB-1:0] lane_start
);
  logic [NUM_WIDTHS-1:0] act_opt   [NB];
  logic [NUM_WIDTHS-1:0] start_opt [NB];

  for (genvar b = 0; b < NB; b++) begin : g_byte
    for (genvar s = 0; s < NUM_WIDTHS; s++) begin : g_width
      localparam int unsigned BPL  = 1 << s;
      localparam int unsigned BASE = (b / BPL) * BPL;
      assign act_opt[b][s]   = pred[BASE];
      assign start_opt[b][s] = (b % BPL) == 0;
    end
    assign byte_active[b] = act_opt[b][width];
    assign lane_start[b]  = start_opt[b][width];
  end
endmodule

// File: rtl/simd_seg_adder.sv
// Byte-sliced adder whose carry chain is broken at every lane start.
module simd_seg_adder #(
  parameter int unsigned NB = 32
) (
  input  logic [NB*8-1:0] opa,
  input  logic [NB*8-1:0] opb,
  input  logic [NB-1:0]   lane_start,
  output logic [NB*8-1:0] sum
);
  logic [NB-2:0] cy;

  for (genvar b = 0; b < NB; b++) begin : g_slice
    logic cin;
    if (b == 0) begin : g_first
      assign cin = 1'b0;
    end else begin : g_rest
      assign cin = lane_start[b] ? 1'b0 : cy[b-1];
    end
    if (b < NB - 1) begin : g_carry
      assign {cy[b], sum[b*8 +: 8]} = {1'b0, opa[b*8 +: 8]} + {1'b0, opb[b*8 +: 8]} + {8'd0, cin};
    end else begin : g_top
      assign sum[b*8 +: 8] = opa[b*8 +: 8] + opb[b*8 +: 8] + {7'd0, cin};
    end
  end
endmodule

// File: rtl/simd_merge_add.sv
module simd_merge_add
  import simd_add_pkg::*;
#(
  parameter int unsigned VL = 256
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [VL-1:0]   in_a,
  input  logic [VL-1:0]   in_b,
  input  logic [VL/8-1:0] in_pred,
  input  logic [1:0]      in_size,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [VL-1:0]   out_result
);
  localparam int unsigned NB = VL / 8;

  lane_width_e   width;
  logic [NB-1:0] byte_active;
  logic [NB-1:0] lane_start;
  logic [VL-1:0] raw_sum;
  logic [VL-1:0] merged;
  logic          take;

  assign width = lane_width_e'(in_size);

  simd_lane_ctrl #(.NB(NB)) u_ctrl (
    .pred        (in_pred),
    .width       (width),
    .byte_active (byte_active),
    .lane_start  (lane_start)
  );

  simd_seg_adder #(.NB(NB)) u_add (
    .opa        (in_a),
    .opb        (in_b),
    .lane_start (lane_start),
    .sum        (raw_sum)
  );

  for (genvar b = 0; b < NB; b++) begin : g_merge
    assign merged[b*8 +: 8] = byte_active[b] ? raw_sum[b*8 +: 8] : in_a[b*8 +: 8];
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) out_result <= merged;
  end
endmodule

// File: rtl/simd_merge_add_chk.sv
module simd_merge_add_chk #(
  parameter int unsigned VL = 256
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic [VL-1:0]   in_a,
  input logic [VL-1:0]   in_b,
  input logic [VL/8-1:0] in_pred,
  input logic [1:0]      in_size,
  input logic            out_valid,
  input logic            out_ready,
  input logic [VL-1:0]   out_result
);
  // R7
  rst_clears_valid_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && in_ready));

  // R5
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  // R6
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R3
  all_inactive_merge_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_pred == '0) |=> (out_result == $past(in_a)));

  // R1
  low_byte_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_size == 2'd0 && in_pred[0]) |=>
      (out_result[7:0] == $past(in_a[7:0] + in_b[7:0])));
endmodule

bind simd_merge_add simd_merge_add_chk #(.VL(VL)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_a       (in_a),
  .in_b       (in_b),
  .in_pred    (in_pred),
  .in_size    (in_size),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result)
);

// File: tb/simd_merge_add_tb.sv
module simd_merge_add_tb;
  localparam int unsigned VL = 256;
  localparam int unsigned NB = VL / 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [VL-1:0]   in_a = '0;
  logic [VL-1:0]   in_b = '0;
  logic [NB-1:0]   in_pred = '0;
  logic [1:0]      in_size = 2'd0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [VL-1:0]   out_result;

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag = "R7";

  always #5 clk = ~clk;

  simd_merge_add #(.VL(VL)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_pred(in_pred), .in_size(in_size),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result)
  );

  function automatic logic [VL-1:0] ref_add(logic [VL-1:0] a, logic [VL-1:0] b,
                                            logic [NB-1:0] p, logic [1:0] sz);
    int unsigned es = 8 << sz;
    logic [VL-1:0] r = a;
    logic [63:0] msk = (es == 64) ? {64{1'b1}} : ((64'd1 << es) - 64'd1);
    for (int l = 0; l < int'(VL / es); l++) begin
      if (p[l * (es / 8)]) begin
        logic [63:0] x = 64'(a >> (l * es)) & msk;
        logic [63:0] y = 64'(b >> (l * es)) & msk;
        logic [63:0] s = (x + y) & msk;
        logic [VL-1:0] wide = {{(VL-64){1'b0}}, msk};
        r = (r & ~(wide << (l * es))) | ({{(VL-64){1'b0}}, s} << (l * es));
      end
    end
    return r;
  endfunction

  // Behavioural model: one-entry queue of expected results.
  logic [VL-1:0] exp_q[$];
  always @(posedge clk) begin
    if (rst) begin
      exp_q.delete();
    end else begin
      automatic bit rdy = (exp_q.size() == 0) || out_ready;
      if (exp_q.size() != 0 && out_ready) void'(exp_q.pop_front());
      if (in_valid && rdy) exp_q.push_back(ref_add(in_a, in_b, in_pred, in_size));
    end
  end

  task automatic check1(string what, logic [VL-1:0] act, logic [VL-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      automatic bit ev = exp_q.size() != 0;
      check1("out_valid", VL'(out_valid), VL'(ev));
      check1("in_ready", VL'(in_ready), VL'(!ev || out_ready));
      if (ev && out_valid) check1("out_result", out_result, exp_q[0]);
    end else begin
      check1("out_valid in reset", VL'(out_valid), '0);
    end
  end

  function automatic logic [VL-1:0] rnd_vec();
    logic [VL-1:0] v;
    for (int i = 0; i < int'(VL / 32); i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [VL-1:0] lane_fill(logic [1:0] sz, logic [63:0] val);
    int unsigned es = 8 << sz;
    logic [VL-1:0] v = '0;
    logic [63:0] msk = (es == 64) ? {64{1'b1}} : ((64'd1 << es) - 64'd1);
    for (int l = 0; l < int'(VL / es); l++)
      v = v | ({{(VL-64){1'b0}}, val & msk} << (l * es));
    return v;
  endfunction

  task automatic send(logic [VL-1:0] a, logic [VL-1:0] b, logic [NB-1:0] p, logic [1:0] sz);
    @(posedge clk); #1;
    in_valid = 1'b1; in_a = a; in_b = b; in_pred = p; in_size = sz;
    while (!in_ready) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    tag = "R7";
    @(posedge clk); #1;
    for (int sz = 0; sz < 4; sz++) begin
      tag = "R1";
      send(rnd_vec(), rnd_vec(), '1, 2'(sz));
      tag = "R3";
      send(rnd_vec(), rnd_vec(), '0, 2'(sz));
      tag = "R2";
      send(lane_fill(2'(sz), '1), lane_fill(2'(sz), 64'd1), '1, 2'(sz));
      send(lane_fill(2'(sz), 64'h8000_0000_0000_0080), lane_fill(2'(sz), 64'h8000_0000_0000_0080), '1, 2'(sz));
      tag = "R4";
      begin
        logic [NB-1:0] hi = '0;
        logic [NB-1:0] lo = '0;
        int bpl = 1 << sz;
        for (int b = 0; b < int'(NB); b++) begin
          if (b % bpl == 0) lo[b] = (b / bpl) % 2 == 0;
          else hi[b] = 1'b1;
        end
        send(rnd_vec(), rnd_vec(), hi, 2'(sz));
        send(rnd_vec(), rnd_vec(), lo | hi, 2'(sz));
      end
      tag = "R1";
      for (int k = 0; k < 10; k++) send(rnd_vec(), rnd_vec(), NB'(rnd_vec()), 2'(sz));
    end
    tag = "R6";
    @(posedge clk); #1;
    out_ready = 1'b0;
    in_valid = 1'b1; in_a = rnd_vec(); in_b = rnd_vec(); in_pred = '1; in_size = 2'd2;
    @(posedge clk); #1;
    in_a = rnd_vec(); in_b = rnd_vec(); in_size = 2'd1;
    repeat (5) @(posedge clk);
    #1 out_ready = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    tag = "R5";
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1;
      in_valid = ($urandom % 3) != 0;
      out_ready = ($urandom % 4) != 0;
      in_a = rnd_vec(); in_b = rnd_vec(); in_pred = NB'(rnd_vec()); in_size = 2'($urandom);
    end
    @(posedge clk); #1;
    in_valid = 1'b0; out_ready = 1'b1;
    tag = "R7";
    repeat (2) @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    repeat (3) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule